// File: doc/BRIEF.md
# Packed Six-Bit Character String Mover and Comparator

This engine copies or compares runs of 6-bit characters held ten to a word in a 60-bit word memory. Each operand is a word address plus a character slot, and a run may begin at any slot. The source and destination slots are independent of each other, so a copy can shift characters across word boundaries. The engine drives a synchronous single-port memory one word at a time. When a destination word is only partly covered by the run, the engine reads it, merges in the new characters and writes it back, so characters outside the run keep their old values.

A command carries the operation, both operands and a length in characters. It is accepted on a valid/ready handshake. The engine stays busy until it pulses done for one cycle. A compare reports whether the source run is equal to, less than or greater than the destination run. A copy reports none of these flags.

Top module: `charstr_engine`

## Requirements
- R1: Slot 1 of a word is bits 59..54 and slot 10 is bits 5..0, with slot k at bits 65-6k..60-6k. A run that passes slot 10 of word A continues at slot 1 of word A+1. Slot inputs take the values 1 to 10.
- R2: A copy (cmd_is_cmp=0) writes cmd_len characters, taken in order from the source run, into consecutive destination slots. The source and destination slot offsets may differ.
- R3: In a destination word that the run covers only in part, every character outside the run keeps its previous value.
- R4: A zero length finishes with no memory write. A zero-length compare reports equal.
- R5: A compare (cmd_is_cmp=1) sets res_eq when all characters match. Otherwise the first differing character decides as an unsigned 6-bit value: res_lt when the source character is smaller, res_gt when it is larger. At most one flag is high at a time, and all three are low after a copy.
- R6: A compare never writes memory.
- R7: cmd_ready is high only while the engine is idle, and a command is taken when cmd_valid and cmd_ready are both high. busy is high from the next cycle through the cycle in which done pulses. done lasts exactly one cycle.
- R8: While reset is asserted, busy, done, the result flags and mem_en are low. cmd_ready rises within three cycles after reset is released.
- R9: Memory reads return mem_rdata one cycle after mem_en. mem_we is only high together with mem_en, and the engine makes no memory access while idle.
- R10: The result flags hold their values from the done cycle until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_is_cmp | input | 1 | 1 = compare, 0 = copy |
| cmd_src_addr | input | 18 | Source word address |
| cmd_src_pos | input | 4 | Source slot, 1..10 |
| cmd_dst_addr | input | 18 | Destination word address |
| cmd_dst_pos | input | 4 | Destination slot, 1..10 |
| cmd_len | input | 12 | Length in characters |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| res_eq | output | 1 | Compare: runs equal |
| res_lt | output | 1 | Compare: source smaller |
| res_gt | output | 1 | Compare: source larger |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 60 | Write data |
| mem_rdata | input | 60 | Read data, one cycle after a read strobe |

## Verification
The bench runs copies whose source and destination slots differ. A design that carried the slot offset wrongly across a word boundary would duplicate or drop the character at the seam. It also runs runs that start and end mid-word on both sides; a design that skipped the merge would overwrite the neighbouring characters, and the full memory image is compared after each copy to catch this. The single-character and slot-10-to-slot-1 cases catch a reversed bit order. Compares with the first mismatch going either way catch a swapped or signed ordering. Zero lengths catch a stray write or a missing equal flag.

// File: rtl/charstr_pkg.sv
package charstr_pkg;
  localparam int unsigned CS_CHAR_W     = 6;
  localparam int unsigned CS_WORD_CHARS = 10;
  localparam int unsigned CS_ADDR_W     = 18;
  localparam int unsigned CS_LEN_W      = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_RD,
    ST_CAP,
    ST_WR,
    ST_DONE
  } cs_state_e;
endpackage

// File: rtl/charstr_rst_sync.sv
module charstr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/charstr_lane_get.sv
module charstr_lane_get #(
  parameter  int unsigned CHAR_W     = 6,
  parameter  int unsigned WORD_CHARS = 10,
  localparam int unsigned WORD_W     = CHAR_W * WORD_CHARS,
  localparam int unsigned POS_W      = $clog2(WORD_CHARS + 1)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic [CHAR_W-1:0] char_o
);
  logic [CHAR_W-1:0] lane [WORD_CHARS];

  // lane 0 is the most significant character of the word
  for (genvar i = 0; i < WORD_CHARS; i++) begin : g_lane
    assign lane[i] = word_i[WORD_W-1-i*CHAR_W -: CHAR_W];
  end

  always_comb begin
    char_o = '0;
    for (int i = 0; i < WORD_CHARS; i++) begin
      if (pos_i == POS_W'(i)) char_o = lane[i];
    end
  end
endmodule

// File: rtl/charstr_lane_put.sv
module charstr_lane_put #(
  parameter  int unsigned CHAR_W     = 6,
  parameter  int unsigned WORD_CHARS = 10,
  localparam int unsigned WORD_W     = CHAR_W * WORD_CHARS,
  localparam int unsigned POS_W      = $clog2(WORD_CHARS + 1)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar i = 0; i < WORD_CHARS; i++) begin : g_lane
    assign word_o[WORD_W-1-i*CHAR_W -: CHAR_W] =
      (pos_i == POS_W'(i)) ? char_i : word_i[WORD_W-1-i*CHAR_W -: CHAR_W];
  end
endmodule

// File: rtl/charstr_char_order.sv
module charstr_char_order #(
  parameter int unsigned CHAR_W = 6
) (
  input  logic [CHAR_W-1:0] a_i,
  input  logic [CHAR_W-1:0] b_i,
  output logic              lt_o,
  output logic              gt_o
);
  assign lt_o = (a_i < b_i);
  assign gt_o = (a_i > b_i);
endmodule

// File: rtl/charstr_engine.sv
module charstr_engine
  import charstr_pkg::*;
#(
  parameter  int unsigned CHAR_W     = CS_CHAR_W,
  parameter  int unsigned WORD_CHARS = CS_WORD_CHARS,
  parameter  int unsigned ADDR_W     = CS_ADDR_W,
  parameter  int unsigned LEN_W      = CS_LEN_W,
  localparam int unsigned WORD_W     = CHAR_W * WORD_CHARS,
  localparam int unsigned POS_W      = $clog2(WORD_CHARS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_cmp,
  input  logic [ADDR_W-1:0] cmd_src_addr,
  input  logic [POS_W-1:0]  cmd_src_pos,
  input  logic [ADDR_W-1:0] cmd_dst_addr,
  input  logic [POS_W-1:0]  cmd_dst_pos,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              busy,
  output logic              done,
  output logic              res_eq,
  output logic              res_lt,
  output logic              res_gt,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_CHARS - 1);

  logic rst_n_s;

  cs_state_e         st_q, st_d;
  logic [ADDR_W-1:0] sa_q, sa_d, da_q, da_d;
  logic [POS_W-1:0]  sp_q, sp_d, dp_q, dp_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [WORD_W-1:0] sbuf_q, sbuf_d, dbuf_q, dbuf_d;
  logic              sv_q, sv_d, dv_q, dv_d;
  logic              dirty_q, dirty_d, cmp_q, cmp_d, rdd_q, rdd_d;
  logic              eq_q, eq_d, lt_q, lt_d, gt_q, gt_d;

  logic [CHAR_W-1:0] s_ch, d_ch;
  logic [WORD_W-1:0] dbuf_merged;
  logic              c_lt, c_gt;
  logic              accept, data_en;

  charstr_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  charstr_lane_get #(.CHAR_W(CHAR_W), .WORD_CHARS(WORD_CHARS)) u_get_src (
    .word_i (sbuf_q),
    .pos_i  (sp_q),
    .char_o (s_ch)
  );

  charstr_lane_get #(.CHAR_W(CHAR_W), .WORD_CHARS(WORD_CHARS)) u_get_dst (
    .word_i (dbuf_q),
    .pos_i  (dp_q),
    .char_o (d_ch)
  );

  charstr_lane_put #(.CHAR_W(CHAR_W), .WORD_CHARS(WORD_CHARS)) u_put_dst (
    .word_i (dbuf_q),
    .pos_i  (dp_q),
    .char_i (s_ch),
    .word_o (dbuf_merged)
  );

  charstr_char_order #(.CHAR_W(CHAR_W)) u_order (
    .a_i  (s_ch),
    .b_i  (d_ch),
    .lt_o (c_lt),
    .gt_o (c_gt)
  );

  assign cmd_ready = rst_n_s && (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign res_eq    = eq_q;
  assign res_lt    = lt_q;
  assign res_gt    = gt_q;
  assign data_en   = accept || busy;

  // next-state logic
  always_comb begin
    st_d      = st_q;
    sa_d      = sa_q;
    da_d      = da_q;
    sp_d      = sp_q;
    dp_d      = dp_q;
    rem_d     = rem_q;
    sbuf_d    = sbuf_q;
    dbuf_d    = dbuf_q;
    sv_d      = sv_q;
    dv_d      = dv_q;
    dirty_d   = dirty_q;
    cmp_d     = cmp_q;
    rdd_d     = rdd_q;
    eq_d      = eq_q;
    lt_d      = lt_q;
    gt_d      = gt_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = da_q;
    mem_wdata = dbuf_q;

    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_RUN;
          sa_d    = cmd_src_addr;
          da_d    = cmd_dst_addr;
          sp_d    = cmd_src_pos - 1'b1;
          dp_d    = cmd_dst_pos - 1'b1;
          rem_d   = cmd_len;
          cmp_d   = cmd_is_cmp;
          sv_d    = 1'b0;
          dv_d    = 1'b0;
          dirty_d = 1'b0;
          eq_d    = 1'b0;
          lt_d    = 1'b0;
          gt_d    = 1'b0;
        end
      end

      ST_RUN: begin
        if (rem_q == '0) begin
          if (dirty_q) begin
            st_d = ST_WR;
          end else begin
            st_d = ST_DONE;
            eq_d = cmp_q;
          end
        end else if (!sv_q) begin
          st_d  = ST_RD;
          rdd_d = 1'b0;
        end else if (!dv_q) begin
          st_d  = ST_RD;
          rdd_d = 1'b1;
        end else begin
          rem_d = rem_q - 1'b1;
          if (sp_q == LAST_POS) begin
            sp_d = '0;
            sa_d = sa_q + 1'b1;
            sv_d = 1'b0;
          end else begin
            sp_d = sp_q + 1'b1;
          end
          if (dp_q == LAST_POS) dp_d = '0;
          else                  dp_d = dp_q + 1'b1;

          if (cmp_q) begin
            if (c_lt || c_gt) begin
              lt_d = c_lt;
              gt_d = c_gt;
              st_d = ST_DONE;
            end else if (dp_q == LAST_POS) begin
              da_d = da_q + 1'b1;
              dv_d = 1'b0;
            end
          end else begin
            dbuf_d  = dbuf_merged;
            dirty_d = 1'b1;
            if (dp_q == LAST_POS) st_d = ST_WR;
          end
        end
      end

      ST_RD: begin
        mem_en   = 1'b1;
        mem_addr = rdd_q ? da_q : sa_q;
        st_d     = ST_CAP;
      end

      ST_CAP: begin
        if (rdd_q) begin
          dbuf_d = mem_rdata;
          dv_d   = 1'b1;
        end else begin
          sbuf_d = mem_rdata;
          sv_d   = 1'b1;
        end
        st_d = ST_RUN;
      end

      ST_WR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = da_q;
        mem_wdata = dbuf_q;
        dirty_d   = 1'b0;
        dv_d      = 1'b0;
        da_d      = da_q + 1'b1;
        st_d      = ST_RUN;
      end

      ST_DONE: st_d = ST_IDLE;

      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= ST_IDLE;
      sv_q    <= 1'b0;
      dv_q    <= 1'b0;
      dirty_q <= 1'b0;
      cmp_q   <= 1'b0;
      eq_q    <= 1'b0;
      lt_q    <= 1'b0;
      gt_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      sv_q    <= sv_d;
      dv_q    <= dv_d;
      dirty_q <= dirty_d;
      cmp_q   <= cmp_d;
      eq_q    <= eq_d;
      lt_q    <= lt_d;
      gt_q    <= gt_d;
    end
  end

  // datapath registers, no reset, enabled only when working
  always_ff @(posedge clk) begin
    if (data_en) begin
      sa_q   <= sa_d;
      da_q   <= da_d;
      sp_q   <= sp_d;
      dp_q   <= dp_d;
      rem_q  <= rem_d;
      sbuf_q <= sbuf_d;
      dbuf_q <= dbuf_d;
      rdd_q  <= rdd_d;
    end
  end
endmodule

// File: rtl/charstr_engine_chk.sv
module charstr_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic cmd_is_cmp,
  input logic busy,
  input logic done,
  input logic res_eq,
  input logic res_lt,
  input logic res_gt,
  input logic mem_en,
  input logic mem_we
);
  logic op_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      op_cmp <= 1'b0;
    else if (cmd_valid && cmd_ready) op_cmp <= cmd_is_cmp;
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy); // R7
  AST_ACCEPT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7
  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_eq, res_lt, res_gt})); // R5
  AST_COPY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_cmp) |-> !(res_eq || res_lt || res_gt)); // R5
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_cmp) |-> !mem_we); // R6
  AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en); // R9
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en); // R9
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable({res_eq, res_lt, res_gt})); // R10
endmodule

bind charstr_engine charstr_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_is_cmp (cmd_is_cmp),
  .busy       (busy),
  .done       (done),
  .res_eq     (res_eq),
  .res_lt     (res_lt),
  .res_gt     (res_gt),
  .mem_en     (mem_en),
  .mem_we     (mem_we)
);

// File: tb/charstr_engine_bench.sv
module charstr_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_is_cmp = 1'b0;
  logic [17:0] cmd_src_addr = '0;
  logic [3:0]  cmd_src_pos = 4'd1;
  logic [17:0] cmd_dst_addr = '0;
  logic [3:0]  cmd_dst_pos = 4'd1;
  logic [11:0] cmd_len = '0;
  logic        busy, done, res_eq, res_lt, res_gt;
  logic        mem_en, mem_we;
  logic [17:0] mem_addr;
  logic [59:0] mem_wdata;
  logic [59:0] mem_rdata;

  logic [59:0] mem  [256];
  logic [59:0] refm [256];

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  int idle_acc = 0;

  typedef struct { bit eq; bit lt; bit gt; string req; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  charstr_engine u_charstr_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_cmp(cmd_is_cmp), .cmd_src_addr(cmd_src_addr), .cmd_src_pos(cmd_src_pos),
    .cmd_dst_addr(cmd_dst_addr), .cmd_dst_pos(cmd_dst_pos), .cmd_len(cmd_len),
    .busy(busy), .done(done), .res_eq(res_eq), .res_lt(res_lt), .res_gt(res_gt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // synchronous single-port memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[7:0]];
      end
      if (rst_n && !busy) idle_acc <= idle_acc + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({res_eq, res_lt, res_gt} == {e.eq, e.lt, e.gt}, e.req, "result flags",
            {61'd0, res_eq, res_lt, res_gt}, {61'd0, e.eq, e.lt, e.gt});
      end
    end
  end

  function automatic logic [5:0] get_ch(logic [59:0] w, int p);
    return w[59-(p-1)*6 -: 6];
  endfunction

  function automatic logic [59:0] put_ch(logic [59:0] w, int p, logic [5:0] c);
    logic [59:0] r;
    r = w;
    r[59-(p-1)*6 -: 6] = c;
    return r;
  endfunction

  task automatic model_move(int sa, int sp, int da, int dp, int len);
    for (int k = 0; k < len; k++) begin
      int s, d;
      s = sa*10 + sp - 1 + k;
      d = da*10 + dp - 1 + k;
      refm[d/10] = put_ch(refm[d/10], d%10 + 1, get_ch(refm[s/10], s%10 + 1));
    end
  endtask

  function automatic int model_cmp(int sa, int sp, int da, int dp, int len);
    for (int k = 0; k < len; k++) begin
      int s, d;
      logic [5:0] a, b;
      s = sa*10 + sp - 1 + k;
      d = da*10 + dp - 1 + k;
      a = get_ch(refm[s/10], s%10 + 1);
      b = get_ch(refm[d/10], d%10 + 1);
      if (a < b) return 1;
      if (a > b) return 2;
    end
    return 0;
  endfunction

  task automatic set_word(int a, logic [59:0] w);
    mem[a]  = w;
    refm[a] = w;
  endtask

  task automatic check_mem(string req);
    int bad;
    int first;
    bad = 0;
    first = -1;
    for (int i = 0; i < 256; i++) begin
      if (mem[i] !== refm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) chk(1'b1, req, "memory image", 64'd0, 64'd0);
    else chk(1'b0, req, "memory image word", {4'd0, mem[first]}, {4'd0, refm[first]});
  endtask

  task automatic run_cmd(bit cmp, int sa, int sp, int da, int dp, int len, string req);
    exp_t e;
    int code;
    int wr_base;
    code = cmp ? model_cmp(sa, sp, da, dp, len) : 0;
    e.eq = cmp && (code == 0);
    e.lt = cmp && (code == 1);
    e.gt = cmp && (code == 2);
    e.req = req;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    wr_base      = wr_cnt;
    cmd_valid    = 1'b1;
    cmd_is_cmp   = cmp;
    cmd_src_addr = 18'(sa);
    cmd_src_pos  = 4'(sp);
    cmd_dst_addr = 18'(da);
    cmd_dst_pos  = 4'(dp);
    cmd_len      = 12'(len);
    sb_q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R7", "busy after accept", {62'd0, busy, cmd_ready}, 64'd2);
    while (!done) @(negedge clk);
    @(negedge clk);
    if (!cmp) begin
      model_move(sa, sp, da, dp, len);
      check_mem(cmp ? "R6" : req);
    end
    if (cmp || len == 0)
      chk(wr_cnt == wr_base, cmp ? "R6" : "R4", "write count",
          64'(wr_cnt - wr_base), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 64'd1, 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      logic [59:0] w;
      for (int j = 0; j < 10; j++) w[59-j*6 -: 6] = 6'(i*7 + j*13 + 5);
      set_word(i, w);
    end

    // R8: reset state
    repeat (3) @(negedge clk);
    chk({busy, done, res_eq, res_lt, res_gt, mem_en} == 6'd0, "R8", "outputs in reset",
        {58'd0, busy, done, res_eq, res_lt, res_gt, mem_en}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R8", "ready after release", {63'd0, cmd_ready}, 64'd1);

    // R1: slot bit placement and continuation into the next word
    set_word(100, {6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9, 6'd10});
    run_cmd(1'b0, 100, 1, 101, 10, 1, "R1");
    chk(mem[101][5:0] == 6'd1, "R1", "slot 10 bits", {58'd0, mem[101][5:0]}, 64'd1);
    run_cmd(1'b0, 100, 10, 102, 1, 2, "R1");
    chk(mem[102][59:54] == 6'd10, "R1", "slot 1 bits", {58'd0, mem[102][59:54]}, 64'd10);
    chk(mem[102][53:48] == get_ch(mem[101], 1), "R1", "next word continues",
        {58'd0, mem[102][53:48]}, {58'd0, get_ch(mem[101], 1)});

    // R2/R3: long shifted move, short mid-word move, aligned full words
    run_cmd(1'b0, 10, 3, 40, 9, 72, "R2");
    run_cmd(1'b0, 5, 2, 60, 6, 4, "R3");
    run_cmd(1'b0, 20, 1, 70, 1, 20, "R2");
    run_cmd(1'b0, 30, 10, 80, 4, 17, "R3");

    // R4: zero lengths
    run_cmd(1'b0, 3, 4, 90, 5, 0, "R4");
    run_cmd(1'b1, 3, 4, 90, 5, 0, "R4");

    // R5: compares
    run_cmd(1'b1, 10, 3, 40, 9, 72, "R5");
    set_word(41, put_ch(refm[41], 5, get_ch(refm[41], 5) ^ 6'h3f));
    run_cmd(1'b1, 10, 3, 40, 9, 72, "R5");
    set_word(120, {10{6'd63}});
    set_word(121, {10{6'd0}});
    run_cmd(1'b1, 120, 1, 121, 1, 10, "R5");
    run_cmd(1'b1, 121, 1, 120, 1, 10, "R5");
    set_word(122, {6'd5, 6'd5, 6'd9, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0});
    set_word(123, {6'd5, 6'd5, 6'd8, 6'd63, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0});
    run_cmd(1'b1, 122, 1, 123, 1, 4, "R5");
    chk(res_gt == 1'b1, "R5", "first difference decides", {63'd0, res_gt}, 64'd1);

    // R10: flags held while idle
    repeat (4) @(negedge clk);
    chk({res_eq, res_lt, res_gt} == 3'b001, "R10", "flags held",
        {61'd0, res_eq, res_lt, res_gt}, 64'd1);

    // R9: no access while idle
    chk(idle_acc == 0, "R9", "idle accesses", 64'(idle_acc), 64'd0);
    chk(sb_q.size() == 0, "R7", "pending results", 64'(sb_q.size()), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule